// File: doc/BRIEF.md
# Bus Idle Watchdog with Restart Sequencer

This block supervises a processor bus and recovers it when it falls silent. A counter measures how long the bus has gone without an access. When the silence reaches a set length, the block behaves as if power had just come back. It holds the bus master reset for a fixed number of cycles. Once the reset has been released, it raises a restart interrupt. A real power restore, seen as a rising edge on the power-good input after a drop, runs through the same reset-then-interrupt sequence. The drop itself raises a separate power-fail interrupt.

A second, independent timer guards the line drivers of an I/O port. Processor accesses to that port keep the drivers enabled. If those accesses stop for long enough, the driver enable falls, so a stalled or unpowered interface cannot disturb a cable shared with a backup interface. The next access to the port turns the drivers back on.

The timeouts and the reset length are parameters counted in clock cycles. The defaults give one second at 200 MHz, and a test can shorten them. Software clears both interrupts with a single acknowledge strobe.

Top module: `bus_guard`

## Requirements
- R1: When `bus_access` is low on IDLE_CYCLES consecutive rising edges, `master_reset` is high after the last of those edges. With fewer idle edges, no restart begins.
- R2: A cycle with `bus_access` high starts the idle count again from zero. Repeated gaps of IDLE_CYCLES-1 idle cycles, each followed by one access, never start a restart.
- R3: `master_reset` stays high for exactly RESET_CYCLES cycles. `restore_irq` rises in the cycle in which `master_reset` falls, and never while it is high.
- R4: `restore_irq` stays high until a cycle with `irq_ack` high. If the interrupt is being set and acknowledged in the same cycle, the set wins.
- R5: A falling edge on `power_good` sets `pfail_irq` on the next edge. It stays high until `irq_ack`.
- R6: While power is down, that is between a power-good fall and the following rise, a bus idle timeout has no effect, and `master_reset` stays low.
- R7: A rising edge on `power_good` after a fall starts the same sequence as R3. `master_reset` is high for RESET_CYCLES cycles, then `restore_irq` is raised.
- R8: If a power-good fall and a bus idle timeout fall on the same edge, the power fail wins. `pfail_irq` is set, and no master reset occurs.
- R9: When `port_access` is low on PORT_CYCLES consecutive edges, `drv_enable` is low after the last of those edges. With fewer idle edges it stays high.
- R10: After the drivers have been disabled, the first edge with `port_access` high sets `drv_enable` high again.
- R11: After reset, `master_reset`, `restore_irq` and `pfail_irq` are low, and `drv_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_access | input | 1 | High in any cycle with an access on the supervised bus |
| port_access | input | 1 | High in any cycle with a processor access to the guarded port |
| power_good | input | 1 | Power supply good level |
| irq_ack | input | 1 | Clears both interrupts |
| master_reset | output | 1 | Bus master reset, high during the restart sequence |
| restore_irq | output | 1 | Restart interrupt, raised after the master reset ends |
| pfail_irq | output | 1 | Power-fail interrupt |
| drv_enable | output | 1 | Enable for the port line drivers |

## Verification
Two of the block's functions can meet on one edge: the bus idle timeout and the power-good fall. The bench leaves the bus idle for IDLE_CYCLES-1 cycles and then drops power-good, so that the edge that completes the timeout also samples the fall. Power-fail must take priority. The check requires `pfail_irq` high, `master_reset` low in that cycle and in the cycles that follow, and no restart interrupt. A second collision occurs when the restart interrupt is set in the same cycle as an acknowledge. The bench expects the interrupt to survive that cycle and clear on the next one.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_DOWN  = 2'd2
  } seq_state_t;

  // Bits needed to count 0 .. n-1
  function automatic int width_for(input int n);
    if (n < 2) return 1;
    return $clog2(n);
  endfunction

  // Sticky interrupt update: a new set beats an acknowledge
  function automatic logic irq_next(input logic cur, input logic set, input logic ack);
    return set | (cur & ~ack);
  endfunction

endpackage

// File: rtl/idle_timer.sv
module idle_timer
  import bus_guard_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic touch,
  output logic expired
);

  localparam int CW = width_for(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] idle_cnt;

  // Fires on the edge that would complete LIMIT idle cycles
  assign expired = !touch && (idle_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (touch || expired) idle_cnt <= '0;
    else                       idle_cnt <= idle_cnt + 1'b1;
  end

  // R2: an access always restarts the count
  a_r2_touch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (idle_cnt == '0));

  // R1: after firing, a full window is needed again
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

endmodule

// File: rtl/restart_seq.sv
module restart_seq
  import bus_guard_pkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_good,
  input  logic bus_expired,
  input  logic irq_ack,
  output logic master_reset,
  output logic restore_irq,
  output logic pfail_irq
);

  localparam int RW = width_for(RESET_CYCLES);
  localparam logic [RW-1:0] RLAST = RW'(RESET_CYCLES - 1);

  seq_state_t    state, state_nxt;
  logic [RW-1:0] rcnt;
  logic          pg_q;
  logic          pg_fall, pg_rise;
  logic          reset_done;
  logic          restore_set;

  assign pg_fall    = pg_q && !power_good;
  assign pg_rise    = !pg_q && power_good;
  assign reset_done = (state == SEQ_RESET) && (rcnt == RLAST);
  assign master_reset = (state == SEQ_RESET);

  always_comb begin
    state_nxt   = state;
    restore_set = 1'b0;
    if (pg_fall) begin
      state_nxt = SEQ_DOWN;
    end else begin
      case (state)
        SEQ_RUN:   if (bus_expired) state_nxt = SEQ_RESET;
        SEQ_DOWN:  if (pg_rise)     state_nxt = SEQ_RESET;
        SEQ_RESET: if (reset_done) begin
                     state_nxt   = SEQ_RUN;
                     restore_set = 1'b1;
                   end
        default:   state_nxt = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_RUN;
      rcnt        <= '0;
      pg_q        <= 1'b1;
      restore_irq <= 1'b0;
      pfail_irq   <= 1'b0;
    end else begin
      state       <= state_nxt;
      pg_q        <= power_good;
      rcnt        <= (master_reset && !reset_done && !pg_fall) ? rcnt + 1'b1 : '0;
      restore_irq <= irq_next(restore_irq, restore_set, irq_ack);
      pfail_irq   <= irq_next(pfail_irq, pg_fall, irq_ack);
    end
  end

  // R3: interrupt only after the reset has been released
  a_r3_irq_follows_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_irq) |-> ($past(master_reset) && !master_reset));

  // R4: interrupt held until acknowledged
  a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_irq && !irq_ack) |=> restore_irq);

  // R5: power fall raises the power-fail interrupt
  a_r5_fall_raises_pfail: assert property (@(posedge clk) disable iff (!rst_n)
    pg_fall |=> pfail_irq);

  // R6: no restart while power stays down
  a_r6_down_blocks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_DOWN && !pg_rise) |=> !master_reset);

  // R8: power fail beats a simultaneous timeout
  a_r8_fail_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_fall && bus_expired) |=> (!master_reset && pfail_irq));

endmodule

// File: rtl/drv_gate.sv
module drv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic port_access,
  input  logic port_expired,
  output logic drv_enable
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            drv_enable <= 1'b1;
    else if (port_expired) drv_enable <= 1'b0;
    else if (port_access)  drv_enable <= 1'b1;
  end

  // R9: expiry disconnects the drivers
  a_r9_expiry_drops: assert property (@(posedge clk) disable iff (!rst_n)
    port_expired |=> !drv_enable);

  // R10: an access reconnects them
  a_r10_access_restores: assert property (@(posedge clk) disable iff (!rst_n)
    port_access |=> drv_enable);

endmodule

// File: rtl/bus_guard.sv
module bus_guard #(
  parameter int IDLE_CYCLES  = 200_000_000,
  parameter int PORT_CYCLES  = 200_000_000,
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_access,
  input  logic port_access,
  input  logic power_good,
  input  logic irq_ack,
  output logic master_reset,
  output logic restore_irq,
  output logic pfail_irq,
  output logic drv_enable
);

  logic bus_expired;
  logic port_expired;

  idle_timer #(.LIMIT(IDLE_CYCLES)) u_bus_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .touch   (bus_access),
    .expired (bus_expired)
  );

  idle_timer #(.LIMIT(PORT_CYCLES)) u_port_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .touch   (port_access),
    .expired (port_expired)
  );

  restart_seq #(.RESET_CYCLES(RESET_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .power_good   (power_good),
    .bus_expired  (bus_expired),
    .irq_ack      (irq_ack),
    .master_reset (master_reset),
    .restore_irq  (restore_irq),
    .pfail_irq    (pfail_irq)
  );

  drv_gate u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_access  (port_access),
    .port_expired (port_expired),
    .drv_enable   (drv_enable)
  );

  // R11: quiet outputs straight out of reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!master_reset && !restore_irq && !pfail_irq && drv_enable));

endmodule

// File: tb/bus_guard_test.sv
`timescale 1ns/1ps
module bus_guard_test;

  localparam int IDLE = 8;
  localparam int PORT = 6;
  localparam int RST  = 3;

  logic clk = 1'b0;
  logic rst_n, bus_access, port_access, power_good, irq_ack;
  logic master_reset, restore_irq, pfail_irq, drv_enable;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #2.5 clk = ~clk;

  bus_guard #(.IDLE_CYCLES(IDLE), .PORT_CYCLES(PORT), .RESET_CYCLES(RST)) uut (
    .clk(clk), .rst_n(rst_n), .bus_access(bus_access), .port_access(port_access),
    .power_good(power_good), .irq_ack(irq_ack), .master_reset(master_reset),
    .restore_irq(restore_irq), .pfail_irq(pfail_irq), .drv_enable(drv_enable)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_access = 1'b1; port_access = 1'b1;
    power_good = 1'b1; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 master_reset", master_reset, 1'b0);
    chk("R11 restore_irq", restore_irq, 1'b0);
    chk("R11 pfail_irq", pfail_irq, 1'b0);
    chk("R11 drv_enable", drv_enable, 1'b1);

    // R1: gaps shorter than the limit never restart
    for (int g = 1; g < IDLE; g++) begin
      bus_access = 1'b0;
      repeat (g) @(negedge clk);
      chk("R1 short gap", master_reset, 1'b0);
      bus_access = 1'b1;
      @(negedge clk);
    end

    // R2: accesses keep restarting the count
    for (int rep = 0; rep < 3; rep++) begin
      bus_access = 1'b0;
      for (int k = 1; k < IDLE; k++) begin
        @(negedge clk);
        chk("R2 renewed", master_reset, 1'b0);
      end
      bus_access = 1'b1;
      @(negedge clk);
    end

    // R1/R3/R4: full timeout, reset window, then interrupt; ack lands on the set edge
    bus_access = 1'b0;
    for (int k = 1; k <= IDLE + RST + 1; k++) begin
      @(negedge clk);
      chk("R1/R3 master_reset", master_reset, (k >= IDLE) && (k < IDLE + RST));
      chk("R3/R4 restore_irq", restore_irq, k == IDLE + RST);
      if (k == IDLE + RST - 1) irq_ack = 1'b1;
      if (k == IDLE + RST + 1) irq_ack = 1'b0;
    end
    bus_access = 1'b1;
    @(negedge clk);

    // R9: port gaps below the limit keep the drivers on
    for (int g = 1; g < PORT; g++) begin
      port_access = 1'b0;
      repeat (g) @(negedge clk);
      chk("R9 short gap", drv_enable, 1'b1);
      port_access = 1'b1;
      @(negedge clk);
    end
    port_access = 1'b0;
    for (int k = 1; k <= PORT + 2; k++) begin
      @(negedge clk);
      chk("R9 drv_enable", drv_enable, k < PORT);
    end
    port_access = 1'b1;
    @(negedge clk);
    chk("R10 drv restored", drv_enable, 1'b1);

    // R5/R6: power fail, then a long idle bus while down
    power_good = 1'b0;
    @(negedge clk);
    chk("R5 pfail_irq", pfail_irq, 1'b1);
    chk("R5 master_reset", master_reset, 1'b0);
    bus_access = 1'b0;
    for (int k = 0; k < 2 * IDLE; k++) begin
      @(negedge clk);
      chk("R6 no reset while down", master_reset, 1'b0);
    end
    chk("R5 pfail held", pfail_irq, 1'b1);
    ack_pulse();
    chk("R5 pfail acked", pfail_irq, 1'b0);

    // R7: power restore runs the reset-then-interrupt sequence
    bus_access = 1'b1;
    power_good = 1'b1;
    for (int k = 1; k <= RST + 1; k++) begin
      @(negedge clk);
      chk("R7 master_reset", master_reset, k <= RST);
      chk("R7 restore_irq", restore_irq, k == RST + 1);
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R4 irq held", restore_irq, 1'b1);
    end
    ack_pulse();
    chk("R4 irq acked", restore_irq, 1'b0);

    // R8: power fall on the same edge as the bus timeout
    bus_access = 1'b0;
    repeat (IDLE - 1) @(negedge clk);
    chk("R8 before collision", master_reset, 1'b0);
    power_good = 1'b0;
    @(negedge clk);
    chk("R8 master_reset", master_reset, 1'b0);
    chk("R8 pfail_irq", pfail_irq, 1'b1);
    chk("R8 restore_irq", restore_irq, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 still no reset", master_reset, 1'b0);
    end
    bus_access = 1'b1;
    ack_pulse();
    power_good = 1'b1;
    for (int k = 1; k <= RST + 1; k++) begin
      @(negedge clk);
      chk("R7 after collision", master_reset, k <= RST);
    end
    chk("R7 irq after collision", restore_irq, 1'b1);
    ack_pulse();
    chk("R4 final ack", restore_irq, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule